// File: doc/BRIEF.md
# Keyed Watchdog Timer with Configuration Lock

The block is a watchdog peripheral on a simple strobe bus: one-cycle write and read strobes, a 12-bit byte address and 32-bit data. An 8-bit counter steps on one of four slow tick inputs, chosen by a code in the configuration word. Each tick input is a one-cycle enable pulse. When the counter steps onto a programmed interrupt value, it can latch an interrupt status bit. When it steps onto a programmed reset value, it can raise a sticky reset request.

Software keeps the timer from expiring by writing a restart key. A separate lock key is one-way. Once it is written, the configuration is frozen and the timer enable is forced on until the block's own reset. The interrupt path has an enable register, a status register, a write-1-to-clear register and a write-1-to-set register.

Top module: `wdog_keyed`

## Requirements
- R1: After `rst_ni` is low, the block comes up in a known state. Configuration reads 0, the counter reads 0, interrupt status and enable read 0, lock state reads 0, and `irq_o` and `rst_req_o` are 0.
- R2: The configuration word at 0x000 is laid out as follows. Bit 0 is the timer enable, bit 1 the interrupt enable and bit 2 the reset enable. Bits 15:8 hold the reset compare value, bits 23:16 the interrupt compare value and bits 26:24 the tick select. All other bits read 0. A read of an unmapped address, 0x004 or the clear/set registers returns 0.
- R3: Tick select codes 1, 2, 3 and 4 pick `tick_i[0]`, `tick_i[1]`, `tick_i[2]` and `tick_i[3]`. Code 0 and codes 5 to 7 stop the counter.
- R4: While the timer enable is 1, each pulse on the selected tick adds one to the counter, which reads at 0x00C bits 7:0. When the counter equals the reset compare value it holds there. While the timer enable is 0, the counter does not move.
- R5: A write whose low byte is 0xB2 to 0x004 sets the counter to 0, whether or not the block is locked. A write of any other low byte to 0x004 leaves the counter unchanged.
- R6: A write whose low byte is 0x3A to 0x008 locks the block. Lock state reads at 0x008 bit 0. Once locked, the block behaves as follows:
  - writes to 0x000 are ignored;
  - the timer enable reads 1 and the counter runs;
  - further lock-key writes change nothing.

  Only `rst_ni` clears the lock. Other values written to 0x008 have no effect.
- R7: The interrupt status bit, read at 0x204 bit 0, is set when a counter step lands on the interrupt compare value. This happens only while the configuration interrupt enable is 1.
- R8: Writing 1 in bit 0 of 0x208 clears the status bit. Writing 1 in bit 0 of 0x20C sets it. Writing 0 to either register changes nothing.
- R9: `irq_o` is high exactly when the status bit is 1 and the interrupt enable register (0x200 bit 0) is 1.
- R10: While the reset enable is 1, a counter step that lands on the reset compare value raises `rst_req_o`. It stays high through restarts until `rst_ni` clears it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| tick_i | input | 4 | One-cycle tick pulses, slowest rate on the highest bit |
| wr_i | input | 1 | Write strobe |
| rd_i | input | 1 | Read strobe |
| addr_i | input | 12 | Byte address |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data, valid in the cycle `rd_i` is high, else 0 |
| irq_o | output | 1 | Interrupt request |
| rst_req_o | output | 1 | Sticky system reset request |

## Verification
The hardest state to reach is the lock and the sticky reset request. Neither can be undone through the bus, so the bench must pull `rst_ni` in the middle of the run to return to a clean state. The stimulus first drives a reset request through a restart and confirms it survives. It then applies a block reset and builds the locked case from scratch: a near-miss lock key, the real key, a blocked configuration write, and counting and restarting under lock. The tick-select decode is covered by a vector table. Each vector pairs a select code with a tick mask that fires every line except, or only, the chosen one.

// File: rtl/wdog_pkg.sv
package wdog_pkg;
  localparam int CNT_W    = 8;
  localparam int SEL_W    = 3;
  localparam int KEY_W    = 8;
  localparam int OFS_W    = 12;

  localparam logic [OFS_W-1:0] OFS_CFG  = 12'h000;
  localparam logic [OFS_W-1:0] OFS_KICK = 12'h004;
  localparam logic [OFS_W-1:0] OFS_LOCK = 12'h008;
  localparam logic [OFS_W-1:0] OFS_CNT  = 12'h00C;
  localparam logic [OFS_W-1:0] OFS_IE   = 12'h200;
  localparam logic [OFS_W-1:0] OFS_STAT = 12'h204;
  localparam logic [OFS_W-1:0] OFS_CLR  = 12'h208;
  localparam logic [OFS_W-1:0] OFS_SET  = 12'h20C;

  localparam logic [KEY_W-1:0] KICK_KEY = 8'hB2;
  localparam logic [KEY_W-1:0] LOCK_KEY = 8'h3A;

  typedef struct packed {
    logic [SEL_W-1:0] tick_sel;
    logic [CNT_W-1:0] int_val;
    logic [CNT_W-1:0] res_val;
    logic             res_en;
    logic             int_en;
    logic             en;
  } wdog_cfg_t;
endpackage

// File: rtl/wdog_regs.sv
module wdog_regs
  import wdog_pkg::*;
#(
  parameter int ADDR_W = 12,
  parameter int DATA_W = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_i,
  input  logic              rd_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic [CNT_W-1:0]  cnt_i,
  input  logic              stat_i,
  output wdog_cfg_t         cfg_o,
  output logic              locked_o,
  output logic              ie_o,
  output logic              kick_o,
  output logic              stat_clr_o,
  output logic              stat_set_o,
  output logic [DATA_W-1:0] rdata_o
);
  localparam int PAD_W = DATA_W - 32;

  wdog_cfg_t cfg_q;
  logic      locked_q, ie_q;
  logic      wr_cfg, wr_kick, wr_lock, wr_ie, wr_clr, wr_set;
  logic [31:0] rd_word;

  assign wr_cfg  = wr_i && (addr_i == ADDR_W'(OFS_CFG));
  assign wr_kick = wr_i && (addr_i == ADDR_W'(OFS_KICK));
  assign wr_lock = wr_i && (addr_i == ADDR_W'(OFS_LOCK));
  assign wr_ie   = wr_i && (addr_i == ADDR_W'(OFS_IE));
  assign wr_clr  = wr_i && (addr_i == ADDR_W'(OFS_CLR));
  assign wr_set  = wr_i && (addr_i == ADDR_W'(OFS_SET));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cfg_q    <= '0;
      locked_q <= 1'b0;
      ie_q     <= 1'b0;
    end else begin
      if (wr_lock && (wdata_i[KEY_W-1:0] == LOCK_KEY)) begin
        locked_q <= 1'b1;
        cfg_q.en <= 1'b1;
      end else if (wr_cfg && !locked_q) begin
        cfg_q.tick_sel <= wdata_i[26:24];
        cfg_q.int_val  <= wdata_i[23:16];
        cfg_q.res_val  <= wdata_i[15:8];
        cfg_q.res_en   <= wdata_i[2];
        cfg_q.int_en   <= wdata_i[1];
        cfg_q.en       <= wdata_i[0];
      end
      if (wr_ie) ie_q <= wdata_i[0];
    end
  end

  assign kick_o     = wr_kick && (wdata_i[KEY_W-1:0] == KICK_KEY);
  assign stat_clr_o = wr_clr && wdata_i[0];
  assign stat_set_o = wr_set && wdata_i[0];

  always_comb begin
    rd_word = '0;
    if (rd_i) begin
      unique case (addr_i)
        ADDR_W'(OFS_CFG):  rd_word = {5'b0, cfg_q.tick_sel, cfg_q.int_val, cfg_q.res_val,
                                      5'b0, cfg_q.res_en, cfg_q.int_en, cfg_q.en};
        ADDR_W'(OFS_LOCK): rd_word = {31'b0, locked_q};
        ADDR_W'(OFS_CNT):  rd_word = 32'(cnt_i);
        ADDR_W'(OFS_IE):   rd_word = {31'b0, ie_q};
        ADDR_W'(OFS_STAT): rd_word = {31'b0, stat_i};
        default:           rd_word = '0;
      endcase
    end
  end

  generate
    if (PAD_W > 0) begin : g_pad
      assign rdata_o = {{PAD_W{1'b0}}, rd_word};
    end else begin : g_nopad
      assign rdata_o = rd_word[DATA_W-1:0];
    end
  endgenerate

  logic wdata_sink;
  assign wdata_sink = ^{wdata_i[DATA_W-1:27], wdata_i[7:3]};

  assign cfg_o    = cfg_q;
  assign locked_o = locked_q;
  assign ie_o     = ie_q;
endmodule

// File: rtl/wdog_tick_sel.sv
module wdog_tick_sel
  import wdog_pkg::*;
#(
  parameter int NUM_TICKS = 4
) (
  input  logic [SEL_W-1:0]     sel_i,
  input  logic [NUM_TICKS-1:0] tick_i,
  output logic                 tick_o
);
  logic [NUM_TICKS-1:0] hit;

  // code 0 stops; code g+1 picks line g; codes past the last line stop
  for (genvar g = 0; g < NUM_TICKS; g++) begin : g_line
    assign hit[g] = tick_i[g] && (sel_i == SEL_W'(g + 1));
  end

  assign tick_o = |hit;
endmodule

// File: rtl/wdog_core.sv
module wdog_core
  import wdog_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             tick_i,
  input  logic             en_i,
  input  logic             int_en_i,
  input  logic             res_en_i,
  input  logic [CNT_W-1:0] int_val_i,
  input  logic [CNT_W-1:0] res_val_i,
  input  logic             kick_i,
  input  logic             stat_clr_i,
  input  logic             stat_set_i,
  input  logic             ie_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic             stat_o,
  output logic             irq_o,
  output logic             rst_req_o
);
  logic [CNT_W-1:0] cnt_q, cnt_nxt;
  logic             stat_q, rst_req_q;
  logic             step, land_int, land_res;

  assign cnt_nxt  = cnt_q + CNT_W'(1);
  assign step     = en_i && tick_i && !kick_i && (cnt_q != res_val_i);
  assign land_int = step && (cnt_nxt == int_val_i);
  assign land_res = step && (cnt_nxt == res_val_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q     <= '0;
      stat_q    <= 1'b0;
      rst_req_q <= 1'b0;
    end else begin
      if (kick_i)    cnt_q <= '0;
      else if (step) cnt_q <= cnt_nxt;

      // setting wins over a same-cycle clear
      if ((land_int && int_en_i) || stat_set_i) stat_q <= 1'b1;
      else if (stat_clr_i)                      stat_q <= 1'b0;

      if (land_res && res_en_i) rst_req_q <= 1'b1;
    end
  end

  assign cnt_o     = cnt_q;
  assign stat_o    = stat_q;
  assign irq_o     = stat_q && ie_i;
  assign rst_req_o = rst_req_q;
endmodule

// File: rtl/wdog_keyed.sv
module wdog_keyed
  import wdog_pkg::*;
#(
  parameter int ADDR_W    = 12,
  parameter int DATA_W    = 32,
  parameter int NUM_TICKS = 4
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic [NUM_TICKS-1:0] tick_i,
  input  logic                 wr_i,
  input  logic                 rd_i,
  input  logic [ADDR_W-1:0]    addr_i,
  input  logic [DATA_W-1:0]    wdata_i,
  output logic [DATA_W-1:0]    rdata_o,
  output logic                 irq_o,
  output logic                 rst_req_o
);
  wdog_cfg_t        cfg_q;
  logic             locked, ie, kick, stat_clr, stat_set, stat, tick_sel;
  logic [CNT_W-1:0] cnt;

  wdog_regs #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_regs (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .wr_i       (wr_i),
    .rd_i       (rd_i),
    .addr_i     (addr_i),
    .wdata_i    (wdata_i),
    .cnt_i      (cnt),
    .stat_i     (stat),
    .cfg_o      (cfg_q),
    .locked_o   (locked),
    .ie_o       (ie),
    .kick_o     (kick),
    .stat_clr_o (stat_clr),
    .stat_set_o (stat_set),
    .rdata_o    (rdata_o)
  );

  wdog_tick_sel #(.NUM_TICKS(NUM_TICKS)) u_tick (
    .sel_i  (cfg_q.tick_sel),
    .tick_i (tick_i),
    .tick_o (tick_sel)
  );

  wdog_core u_core (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .tick_i     (tick_sel),
    .en_i       (cfg_q.en),
    .int_en_i   (cfg_q.int_en),
    .res_en_i   (cfg_q.res_en),
    .int_val_i  (cfg_q.int_val),
    .res_val_i  (cfg_q.res_val),
    .kick_i     (kick),
    .stat_clr_i (stat_clr),
    .stat_set_i (stat_set),
    .ie_i       (ie),
    .cnt_o      (cnt),
    .stat_o     (stat),
    .irq_o      (irq_o),
    .rst_req_o  (rst_req_o)
  );
endmodule

// File: rtl/wdog_keyed_chk.sv
module wdog_keyed_chk
  import wdog_pkg::*;
#(
  parameter int ADDR_W = 12,
  parameter int DATA_W = 32
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              wr_i,
  input logic [ADDR_W-1:0] addr_i,
  input logic [DATA_W-1:0] wdata_i,
  input logic              rst_req_o,
  input logic              locked,
  input wdog_cfg_t         cfg_q,
  input logic [CNT_W-1:0]  cnt,
  input logic              stat
);
  AST_RST_REQ_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rst_req_o |=> rst_req_o); // R10

  AST_LOCK_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    locked |=> locked); // R6

  AST_LOCK_FORCES_EN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    locked |-> cfg_q.en); // R6

  AST_CFG_FROZEN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (locked && wr_i && (addr_i == ADDR_W'(OFS_CFG))) |=> $stable(cfg_q)); // R6

  AST_CNT_STEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(cnt) |-> ((cnt == $past(cnt) + CNT_W'(1)) || (cnt == '0))); // R4

  AST_KICK_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_i && (addr_i == ADDR_W'(OFS_KICK)) && (wdata_i[KEY_W-1:0] == KICK_KEY))
      |=> (cnt == '0)); // R5

  AST_STAT_SET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_i && (addr_i == ADDR_W'(OFS_SET)) && wdata_i[0]) |=> stat); // R8
endmodule

bind wdog_keyed wdog_keyed_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .wr_i      (wr_i),
  .addr_i    (addr_i),
  .wdata_i   (wdata_i),
  .rst_req_o (rst_req_o),
  .locked    (locked),
  .cfg_q     (cfg_q),
  .cnt       (cnt),
  .stat      (stat)
);

// File: tb/tb_wdog_keyed.sv
`timescale 1ns/1ps
module tb_wdog_keyed;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic [3:0]  tick_i = '0;
  logic        wr_i = 1'b0, rd_i = 1'b0;
  logic [11:0] addr_i = '0;
  logic [31:0] wdata_i = '0;
  logic [31:0] rdata_o;
  logic        irq_o, rst_req_o;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #2.5 clk_i = ~clk_i;

  wdog_keyed dut (.*);

  // {tick select, tick mask, expected count after one pulse}
  localparam logic [14:0] VEC [10] = '{
    {3'd1, 4'b0001, 8'd1}, {3'd1, 4'b1110, 8'd0},
    {3'd2, 4'b0010, 8'd1}, {3'd2, 4'b1101, 8'd0},
    {3'd3, 4'b0100, 8'd1}, {3'd4, 4'b1000, 8'd1},
    {3'd4, 4'b0111, 8'd0}, {3'd0, 4'b1111, 8'd0},
    {3'd5, 4'b1111, 8'd0}, {3'd7, 4'b1111, 8'd0}
  };

  function automatic logic [31:0] cfgw(logic [2:0] sel, logic [7:0] iv, logic [7:0] rv,
                                       logic ren, logic ien, logic en);
    return {5'b0, sel, iv, rv, 5'b0, ren, ien, en};
  endfunction

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(logic [11:0] a, logic [31:0] d);
    @(negedge clk_i);
    wr_i = 1'b1; addr_i = a; wdata_i = d;
    @(posedge clk_i);
    @(negedge clk_i);
    wr_i = 1'b0;
  endtask

  task automatic rd(logic [11:0] a, output logic [31:0] d);
    @(negedge clk_i);
    rd_i = 1'b1; addr_i = a;
    #1 d = rdata_o;
    rd_i = 1'b0;
  endtask

  task automatic tick(logic [3:0] m, int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk_i); tick_i = m;
      @(posedge clk_i);
      @(negedge clk_i); tick_i = '0;
    end
  endtask

  task automatic do_reset();
    @(negedge clk_i); rst_ni = 1'b0;
    repeat (2) @(negedge clk_i);
    rst_ni = 1'b1;
  endtask

  initial begin
    logic [31:0] d;
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;

    // R1 reset state
    rd(12'h000, d); check("R1 cfg", d, 0);
    rd(12'h00C, d); check("R1 count", d, 0);
    rd(12'h204, d); check("R1 status", d, 0);
    rd(12'h008, d); check("R1 lock", d, 0);
    check("R1 irq_o", {31'b0, irq_o}, 0);
    check("R1 rst_req_o", {31'b0, rst_req_o}, 0);

    // R2 field layout and unmapped reads
    wr(12'h000, 32'hFFFF_FFFF);
    rd(12'h000, d); check("R2 cfg readback", d, 32'h07FF_FF07);
    rd(12'h010, d); check("R2 unmapped", d, 0);
    rd(12'h004, d); check("R2 kick reads zero", d, 0);
    rd(12'h20C, d); check("R2 set reads zero", d, 0);

    // R3 tick select table
    foreach (VEC[i]) begin
      wr(12'h000, cfgw(VEC[i][14:12], 8'h00, 8'hFF, 1'b0, 1'b0, 1'b1));
      wr(12'h004, 32'hB2);
      tick(VEC[i][11:8], 1);
      rd(12'h00C, d); check($sformatf("R3 vec %0d", i), d, {24'b0, VEC[i][7:0]});
    end

    // R4 counting, saturation, enable off
    wr(12'h000, cfgw(3'd1, 8'h00, 8'h03, 1'b0, 1'b0, 1'b1));
    wr(12'h004, 32'hB2);
    tick(4'b0001, 2);
    rd(12'h00C, d); check("R4 two steps", d, 2);
    tick(4'b0001, 4);
    rd(12'h00C, d); check("R4 saturate", d, 3);
    check("R10 no req when disabled", {31'b0, rst_req_o}, 0);
    wr(12'h000, cfgw(3'd1, 8'h00, 8'hFF, 1'b0, 1'b0, 1'b0));
    wr(12'h004, 32'hB2);
    tick(4'b0001, 3);
    rd(12'h00C, d); check("R4 enable off", d, 0);

    // R5 restart key
    wr(12'h000, cfgw(3'd1, 8'h00, 8'hFF, 1'b0, 1'b0, 1'b1));
    tick(4'b0001, 2);
    wr(12'h004, 32'hB3);
    rd(12'h00C, d); check("R5 wrong key ignored", d, 2);
    wr(12'h004, 32'h1B2);
    rd(12'h00C, d); check("R5 key restarts", d, 0);

    // R7 R8 R9 interrupt path
    wr(12'h000, cfgw(3'd1, 8'h02, 8'hFF, 1'b0, 1'b0, 1'b1));
    wr(12'h004, 32'hB2);
    tick(4'b0001, 2);
    rd(12'h204, d); check("R7 no status with int_en 0", d, 0);
    wr(12'h000, cfgw(3'd1, 8'h02, 8'hFF, 1'b0, 1'b1, 1'b1));
    wr(12'h004, 32'hB2);
    tick(4'b0001, 1);
    rd(12'h204, d); check("R7 not yet at match", d, 0);
    tick(4'b0001, 1);
    rd(12'h204, d); check("R7 status on match", d, 1);
    check("R9 irq masked", {31'b0, irq_o}, 0);
    wr(12'h200, 32'h1);
    check("R9 irq enabled", {31'b0, irq_o}, 1);
    wr(12'h208, 32'h0);
    rd(12'h204, d); check("R8 clear with 0 no effect", d, 1);
    wr(12'h208, 32'h1);
    rd(12'h204, d); check("R8 clear", d, 0);
    check("R9 irq drops", {31'b0, irq_o}, 0);
    wr(12'h20C, 32'h0);
    rd(12'h204, d); check("R8 set with 0 no effect", d, 0);
    wr(12'h20C, 32'h1);
    rd(12'h204, d); check("R8 set", d, 1);
    check("R9 irq from set", {31'b0, irq_o}, 1);
    wr(12'h208, 32'h1);

    // R10 sticky reset request
    wr(12'h000, cfgw(3'd1, 8'h00, 8'h03, 1'b1, 1'b0, 1'b1));
    wr(12'h004, 32'hB2);
    tick(4'b0001, 2);
    check("R10 below value", {31'b0, rst_req_o}, 0);
    tick(4'b0001, 1);
    check("R10 request raised", {31'b0, rst_req_o}, 1);
    wr(12'h004, 32'hB2);
    check("R10 survives restart", {31'b0, rst_req_o}, 1);
    do_reset();
    check("R10 cleared by reset", {31'b0, rst_req_o}, 0);
    rd(12'h200, d); check("R1 ie after reset", d, 0);

    // R6 lock
    wr(12'h000, cfgw(3'd1, 8'h00, 8'hFF, 1'b0, 1'b0, 1'b0));
    wr(12'h008, 32'h3B);
    rd(12'h008, d); check("R6 wrong lock key", d, 0);
    rd(12'h000, d); check("R6 cfg before lock", d, 32'h0100_FF00);
    wr(12'h008, 32'h3A);
    rd(12'h008, d); check("R6 locked", d, 1);
    rd(12'h000, d); check("R6 enable forced", d, 32'h0100_FF01);
    wr(12'h000, 32'h0);
    rd(12'h000, d); check("R6 cfg write blocked", d, 32'h0100_FF01);
    tick(4'b0001, 1);
    rd(12'h00C, d); check("R6 runs when locked", d, 1);
    wr(12'h004, 32'hB2);
    rd(12'h00C, d); check("R5 restart while locked", d, 0);
    wr(12'h008, 32'h3A);
    rd(12'h000, d); check("R6 relock no change", d, 32'h0100_FF01);
    do_reset();
    rd(12'h008, d); check("R6 reset unlocks", d, 0);

    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk_i);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule